// File: doc/BRIEF.md
# Selectable Clock Output Divider

This block turns one fast source clock into four identical, slower clocks. The source is chosen glitch-free from three clock inputs. The normal source is a fast synthesized clock. When the bypass input is set, the source is instead a reference clock, and a second glitch-free selector picks that reference from either a crystal-oscillator clock or a single-ended test clock. A two-bit code selects an integer divide ratio of 3, 4, 6 or 12. Every ratio, including the odd ratio of 3, gives a 50% duty cycle.

A change of the ratio code is synchronised into the divided domain. It is applied only when the divider finishes a full output period, or on the first cycle after reset, so no short pulse ever reaches the outputs. An active-high master reset holds the divider and forces all four outputs low. An output-enable input controls the outputs. Each output is modelled as a data bit plus an enable bit: an enable of 0 means the pin is high impedance.

Top module: `fanout_clk_div`

## Requirements
- R1: The ratio code `div_sel` selects the output period in source-clock cycles: 2'b00 gives 3, 2'b01 gives 4, 2'b10 gives 6 and 2'b11 gives 12.
- R2: For every ratio, the high time of each output is half the output period. For the ratio of 3 this is 1.5 source cycles.
- R3: All four data outputs `clk_q[3:0]` carry the same waveform at all times.
- R4: While `mstr_rst` is 1, all data outputs are 0 and the divider is held. After `mstr_rst` returns to 0, the first transition on the outputs is a rising edge.
- R5: When `out_en` is 0, every bit of `clk_oe` is 0 (high impedance) and the divided data keeps running. When `out_en` is 1, every bit of `clk_oe` is 1.
- R6: When `bypass` is 0, the divider runs from `vco_clk`. When `bypass` is 1, it runs from the selected reference clock, using the same ratio.
- R7: When `ref_sel` is 0, the reference is `xtal_clk`. When `ref_sel` is 1, the reference is `test_clk`.
- R8: A new ratio code takes effect only at the end of a complete output period. While the ratio changes, no output pulse is shorter than the smaller of the half-periods of the old and new ratios.
- R9: Changing `bypass` or `ref_sel` while the outputs run produces no output pulse shorter than half of the shortest legal output period for the current ratio, and at no time do both legs of a clock selector pass their clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast synthesized source clock |
| xtal_clk | input | 1 | Crystal-oscillator reference clock |
| test_clk | input | 1 | Single-ended test reference clock |
| ref_sel | input | 1 | Reference choice: 1 selects test_clk, 0 selects xtal_clk |
| bypass | input | 1 | 1 divides the reference clock instead of vco_clk |
| div_sel | input | 2 | Ratio code: 00 gives 3, 01 gives 4, 10 gives 6, 11 gives 12 |
| mstr_rst | input | 1 | Active-high master reset |
| out_en | input | 1 | Output enable, 1 means the outputs are driven |
| clk_q | output | 4 | Divided clock data for the four outputs |
| clk_oe | output | 4 | Per-output drive enable, 0 means high impedance |

## Verification
The hardest cases to reach from the ports are a ratio code or clock-source change that arrives in the middle of a run. These are the cases where a runt pulse could escape. The odd-ratio half-cycle output also depends on both clock edges. The bench changes the ratio code and the source selects at odd offsets while output pulses are in flight. It checks the width of every output pulse against a floor derived from the ratios involved. It then measures the period and high time again after the change has settled.

// File: rtl/fanout_clk_div_pkg.sv
package fanout_clk_div_pkg;
  // Width of the ratio select code and the number of selectable ratios
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned NUM_RATIO = 1 << SEL_W;
  // Largest ratio the counter must hold
  localparam int unsigned DIV_MAX   = 12;
  localparam int unsigned CNT_W     = $clog2(DIV_MAX + 1);

  typedef logic [CNT_W-1:0] ratio_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_R0 = 2'b00,
    SEL_R1 = 2'b01,
    SEL_R2 = 2'b10,
    SEL_R3 = 2'b11
  } ratio_code_e;
endpackage

// File: rtl/fck_sync_chain.sv
// Multi-stage synchroniser with asynchronous active-low assertion.
module fck_sync_chain #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fck_glitchless_mux.sv
// Two-input clock selector: each leg enables on its own falling edge
// only after the other leg has been shut off.
module fck_glitchless_mux #(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk_a,
  input  logic       clk_b,
  input  logic       sel_b,
  input  logic       rst_n,
  output logic       clk_o,
  output logic [1:0] en_o
);
  logic [STAGES-1:0] a_sh_q, a_sh_d;
  logic [STAGES-1:0] b_sh_q, b_sh_d;
  logic              en_a, en_b;
  logic              req_a, req_b;

  assign en_a  = a_sh_q[STAGES-1];
  assign en_b  = b_sh_q[STAGES-1];
  assign req_a = ~sel_b & ~en_b;
  assign req_b =  sel_b & ~en_a;

  always_comb begin
    a_sh_d = {a_sh_q[STAGES-2:0], req_a};
    b_sh_d = {b_sh_q[STAGES-2:0], req_b};
  end

  always_ff @(negedge clk_a or negedge rst_n) begin
    if (!rst_n) a_sh_q <= '0;
    else        a_sh_q <= a_sh_d;
  end

  always_ff @(negedge clk_b or negedge rst_n) begin
    if (!rst_n) b_sh_q <= '0;
    else        b_sh_q <= b_sh_d;
  end

  assign clk_o = (clk_a & en_a) | (clk_b & en_b);
  assign en_o  = {en_b, en_a};
endmodule

// File: rtl/fck_div_core.sv
// Integer divider with 50% duty for odd and even ratios.
// One counter is shared. Each output has its own rising-edge flop and
// falling-edge retime flop so that fanout is split per pin.
module fck_div_core
  import fanout_clk_div_pkg::*;
#(
  parameter int unsigned NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ratio_t             ratio_req_i,
  output logic [NUM_OUT-1:0] q_o,
  output ratio_t             cnt_o,
  output ratio_t             ratio_o,
  output logic               armed_o
);
  localparam int unsigned EXT_W = CNT_W + 1;

  ratio_t             cnt_q, cnt_d;
  ratio_t             ratio_q, ratio_d;
  logic               armed_q, armed_d;
  logic               odd_q, odd_d;
  logic [NUM_OUT-1:0] rise_q, rise_d;
  logic [NUM_OUT-1:0] fall_q;
  logic               wrap;
  logic               rise_bit;
  logic [EXT_W-1:0]   ratio_ext;
  logic [EXT_W-1:0]   low_len;

  // Next-state logic
  always_comb begin
    wrap    = armed_q && (cnt_q == ratio_q - ratio_t'(1));
    armed_d = 1'b1;
    if (!armed_q || wrap) begin
      cnt_d   = '0;
      ratio_d = ratio_req_i;
    end else begin
      cnt_d   = cnt_q + ratio_t'(1);
      ratio_d = ratio_q;
    end
    odd_d     = ratio_d[0];
    ratio_ext = {1'b0, ratio_d};
    // Low phase is floor(N/2) counts, high phase ceil(N/2) counts
    low_len   = ratio_ext - ((ratio_ext + EXT_W'(1)) >> 1);
    rise_bit  = armed_q && ({1'b0, cnt_d} >= low_len);
    rise_d    = {NUM_OUT{rise_bit}};
  end

  // Rising-edge state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= ratio_t'(DIV_MAX);
      armed_q <= 1'b0;
      odd_q   <= 1'b0;
      rise_q  <= '0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      armed_q <= armed_d;
      odd_q   <= odd_d;
      rise_q  <= rise_d;
    end
  end

  // Per-output falling-edge retime and output shaping
  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q[g] <= 1'b0;
        else        fall_q[g] <= rise_q[g];
      end
      // Odd ratios: the AND trims the high phase by half a source cycle
      assign q_o[g] = odd_q ? (rise_q[g] & fall_q[g]) : rise_q[g];
    end
  endgenerate

  assign cnt_o   = cnt_q;
  assign ratio_o = ratio_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/fanout_clk_div.sv
module fanout_clk_div
  import fanout_clk_div_pkg::*;
#(
  parameter int unsigned NUM_OUT     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RATIO_0     = 3,
  parameter int unsigned RATIO_1     = 4,
  parameter int unsigned RATIO_2     = 6,
  parameter int unsigned RATIO_3     = 12
) (
  input  logic               vco_clk,
  input  logic               xtal_clk,
  input  logic               test_clk,
  input  logic               ref_sel,
  input  logic               bypass,
  input  logic [SEL_W-1:0]   div_sel,
  input  logic               mstr_rst,
  input  logic               out_en,
  output logic [NUM_OUT-1:0] clk_q,
  output logic [NUM_OUT-1:0] clk_oe
);
  logic             rst_n;
  logic             ref_clk;
  logic             src_clk;
  logic [1:0]       ref_en;
  logic [1:0]       src_en;
  logic             div_rst_n;
  logic [SEL_W-1:0] sel_sync;
  ratio_t           ratio_req;
  ratio_t           cnt;
  ratio_t           ratio;
  logic             armed;

  assign rst_n = ~mstr_rst;

  // Reference choice: crystal or test clock
  fck_glitchless_mux #(.STAGES(SYNC_STAGES)) u_ref_mux (
    .clk_a (xtal_clk),
    .clk_b (test_clk),
    .sel_b (ref_sel),
    .rst_n (rst_n),
    .clk_o (ref_clk),
    .en_o  (ref_en)
  );

  // Source choice: synthesized clock or reference
  fck_glitchless_mux #(.STAGES(SYNC_STAGES)) u_src_mux (
    .clk_a (vco_clk),
    .clk_b (ref_clk),
    .sel_b (bypass),
    .rst_n (rst_n),
    .clk_o (src_clk),
    .en_o  (src_en)
  );

  // Reset release is synchronous to the divided domain
  fck_sync_chain #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (src_clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (div_rst_n)
  );

  fck_sync_chain #(.WIDTH(SEL_W), .STAGES(SYNC_STAGES), .RST_VAL({SEL_W{1'b1}})) u_sel_sync (
    .clk   (src_clk),
    .rst_n (rst_n),
    .d_i   (div_sel),
    .q_o   (sel_sync)
  );

  always_comb begin
    unique case (ratio_code_e'(sel_sync))
      SEL_R0:  ratio_req = ratio_t'(RATIO_0);
      SEL_R1:  ratio_req = ratio_t'(RATIO_1);
      SEL_R2:  ratio_req = ratio_t'(RATIO_2);
      default: ratio_req = ratio_t'(RATIO_3);
    endcase
  end

  fck_div_core #(.NUM_OUT(NUM_OUT)) u_div (
    .clk         (src_clk),
    .rst_n       (div_rst_n),
    .ratio_req_i (ratio_req),
    .q_o         (clk_q),
    .cnt_o       (cnt),
    .ratio_o     (ratio),
    .armed_o     (armed)
  );

  assign clk_oe = {NUM_OUT{out_en}};
endmodule

// File: rtl/fanout_clk_div_chk.sv
module fanout_clk_div_chk
  import fanout_clk_div_pkg::*;
#(
  parameter int unsigned NUM_OUT = 4
) (
  input logic               vco_clk,
  input logic               src_clk,
  input logic               mstr_rst,
  input logic               div_rst_n,
  input logic [NUM_OUT-1:0] clk_q,
  input logic [1:0]         ref_en,
  input logic [1:0]         src_en,
  input ratio_t             cnt,
  input ratio_t             ratio,
  input logic               armed
);
  // R4
  reset_low_chk: assert property (@(posedge vco_clk)
    (mstr_rst && $past(mstr_rst)) |-> (clk_q == '0));

  // R3
  outs_equal_rise_chk: assert property (@(posedge src_clk) disable iff (!div_rst_n)
    (clk_q == '0) || (clk_q == '1));

  // R3
  outs_equal_fall_chk: assert property (@(negedge src_clk) disable iff (!div_rst_n)
    (clk_q == '0) || (clk_q == '1));

  // R1
  cnt_in_range_chk: assert property (@(posedge src_clk) disable iff (!div_rst_n)
    armed |-> (cnt < ratio));

  // R8
  ratio_at_boundary_chk: assert property (@(posedge src_clk) disable iff (!div_rst_n)
    (armed && $past(armed) && (ratio != $past(ratio))) |->
      ($past(cnt) == $past(ratio) - ratio_t'(1)));

  // R9
  src_mux_excl_chk: assert property (@(posedge vco_clk) disable iff (mstr_rst)
    $onehot0(src_en));

  // R9
  ref_mux_excl_chk: assert property (@(posedge vco_clk) disable iff (mstr_rst)
    $onehot0(ref_en));
endmodule

bind fanout_clk_div fanout_clk_div_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .vco_clk   (vco_clk),
  .src_clk   (src_clk),
  .mstr_rst  (mstr_rst),
  .div_rst_n (div_rst_n),
  .clk_q     (clk_q),
  .ref_en    (ref_en),
  .src_en    (src_en),
  .cnt       (cnt),
  .ratio     (ratio),
  .armed     (armed)
);

// File: tb/fanout_clk_div_bench.sv
`timescale 1ns/1ps
module fanout_clk_div_bench;
  localparam real CLK_PERIOD  = 4.0;
  localparam real XTAL_PERIOD = 10.0;
  localparam real TEST_PERIOD = 14.0;
  localparam real TOL         = 0.05;

  logic       vco_clk  = 1'b0;
  logic       xtal_clk = 1'b0;
  logic       test_clk = 1'b0;
  logic       ref_sel  = 1'b0;
  logic       bypass   = 1'b0;
  logic [1:0] div_sel  = 2'b11;
  logic       mstr_rst = 1'b0;
  logic       out_en   = 1'b1;
  logic [3:0] clk_q;
  logic [3:0] clk_oe;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2)  vco_clk  = ~vco_clk;
  always #(XTAL_PERIOD/2) xtal_clk = ~xtal_clk;
  always #(TEST_PERIOD/2) test_clk = ~test_clk;

  fanout_clk_div u_fanout_clk_div (
    .vco_clk  (vco_clk),
    .xtal_clk (xtal_clk),
    .test_clk (test_clk),
    .ref_sel  (ref_sel),
    .bypass   (bypass),
    .div_sel  (div_sel),
    .mstr_rst (mstr_rst),
    .out_en   (out_en),
    .clk_q    (clk_q),
    .clk_oe   (clk_oe)
  );

  // Pulse-width monitor for the runt checks
  bit  mon_on  = 1'b0;
  real mon_min = 0.0;
  real last_t  = -1.0;
  int  runts   = 0;
  always @(clk_q[0]) begin
    if (mon_on && last_t >= 0.0 && ($realtime - last_t) < mon_min) runts++;
    last_t = $realtime;
  end

  task automatic chk_real(input string tag, input real act, input real exp);
    checks++;
    if (act < exp - TOL || act > exp + TOL) begin
      fails++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
    end
  endtask

  task automatic chk_bits(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Settle, then measure one period and its high time
  task automatic measure(input string tag, input real n, input real tsrc);
    real r1, f1, r2;
    repeat (3) @(posedge clk_q[0]);
    r1 = $realtime;
    #(0.25 * n * tsrc);
    chk_bits("R3 all outputs high", clk_q, 4'hF);
    @(negedge clk_q[0]);
    f1 = $realtime;
    #(0.25 * n * tsrc);
    chk_bits("R3 all outputs low", clk_q, 4'h0);
    @(posedge clk_q[0]);
    r2 = $realtime;
    chk_real({tag, " period"}, r2 - r1, n * tsrc);
    chk_real("R2 high time", f1 - r1, n * tsrc / 2.0);
  endtask

  task automatic t_reset_state;
    chk_bits("R4 outputs low in reset", clk_q, 4'h0);
    chk_bits("R5 enables driven", clk_oe, 4'hF);
    #13;
    chk_bits("R4 outputs held low", clk_q, 4'h0);
  endtask

  task automatic t_release;
    mstr_rst = 1'b0;
    @(clk_q[0]);
    chk_bits("R4 first edge rising", {3'b0, clk_q[0]}, 4'h1);
  endtask

  task automatic t_ratios_vco;
    div_sel = 2'b11; measure("R1 ratio 12 vco", 12.0, CLK_PERIOD);
    div_sel = 2'b00; measure("R1 ratio 3 vco", 3.0, CLK_PERIOD);
    div_sel = 2'b01; measure("R1 ratio 4 vco", 4.0, CLK_PERIOD);
    div_sel = 2'b10; measure("R1 ratio 6 vco", 6.0, CLK_PERIOD);
  endtask

  task automatic t_bypass_refs;
    bypass = 1'b1; ref_sel = 1'b0;
    div_sel = 2'b00; measure("R6 bypass xtal ratio 3", 3.0, XTAL_PERIOD);
    div_sel = 2'b11; measure("R6 bypass xtal ratio 12", 12.0, XTAL_PERIOD);
    ref_sel = 1'b1;
    div_sel = 2'b10; measure("R7 bypass test ratio 6", 6.0, TEST_PERIOD);
    ref_sel = 1'b0;  measure("R7 back to xtal ratio 6", 6.0, XTAL_PERIOD);
    bypass = 1'b0;   measure("R6 back to vco ratio 6", 6.0, CLK_PERIOD);
  endtask

  task automatic t_out_en;
    out_en = 1'b0;
    #1;
    chk_bits("R5 enables released", clk_oe, 4'h0);
    div_sel = 2'b01;
    measure("R5 data runs while floated", 4.0, CLK_PERIOD);
    out_en = 1'b1;
    #1;
    chk_bits("R5 enables restored", clk_oe, 4'hF);
  endtask

  task automatic t_ratio_change;
    div_sel = 2'b11;
    repeat (3) @(posedge clk_q[0]);
    runts = 0; mon_min = 6.0 - TOL; mon_on = 1'b1;
    #17;  div_sel = 2'b00;
    #97;  div_sel = 2'b10;
    #31;  div_sel = 2'b00;
    #203; div_sel = 2'b11;
    #59;  div_sel = 2'b01;
    #150;
    mon_on = 1'b0;
    checks++;
    if (runts != 0) begin
      fails++;
      $display("FAIL R8 runt pulses actual=%0d expected=0", runts);
    end
    measure("R8 ratio 4 after changes", 4.0, CLK_PERIOD);
  endtask

  task automatic t_src_switch;
    div_sel = 2'b01;
    repeat (3) @(posedge clk_q[0]);
    runts = 0; mon_min = 8.0 - TOL; mon_on = 1'b1;
    #9;   bypass  = 1'b1;
    #113; ref_sel = 1'b1;
    #77;  ref_sel = 1'b0;
    #151; bypass  = 1'b0;
    #43;  bypass  = 1'b1;
    #200;
    mon_on = 1'b0;
    checks++;
    if (runts != 0) begin
      fails++;
      $display("FAIL R9 runt pulses actual=%0d expected=0", runts);
    end
    measure("R9 xtal ratio 4 after switching", 4.0, XTAL_PERIOD);
    bypass = 1'b0;
  endtask

  task automatic t_master_reset;
    div_sel = 2'b10;
    repeat (2) @(posedge clk_q[0]);
    #7;
    mstr_rst = 1'b1;
    #1;
    chk_bits("R4 reset forces low", clk_q, 4'h0);
    #150;
    chk_bits("R4 outputs held in reset", clk_q, 4'h0);
    t_release();
    measure("R4 resumed ratio 6", 6.0, CLK_PERIOD);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog (R1) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    #1;
    mstr_rst = 1'b1;
    #40;
    t_reset_state();
    t_release();
    t_ratios_vco();
    t_bypass_refs();
    t_out_en();
    t_ratio_change();
    t_src_switch();
    t_master_reset();
    finish_run();
  end
endmodule